// File: doc/BRIEF.md
# Horizontal Oversize Blanking Timer

This block produces one active-high blanking level for a display deflection path. It merges a per-line horizontal blanking window with a vertical blanking input. The horizontal window is placed around the rising edge of the positive horizontal flyback pulse. It opens a fixed lead time before that edge and closes a fixed trail time after it. Two aspect-ratio settings are supported, and a disable setting turns the horizontal window off.

Because the window has to open before the edge arrives, the block cannot simply trigger on the edge. It measures the number of clock cycles between successive flyback rising edges and uses that period to predict when the next edge will come. The lead and trail times are given in nanoseconds as parameters and converted to cycle counts from the clock frequency. All interfaces are plain level pins with no handshake. The flyback level is asynchronous and passes through a synchronizer inside the block.

Top module: `hob_timer`

## Requirements
- R1: While reset is asserted, and after it is released until the first stimulus, `blank_o` is low and no line period is known.
- R2: The flyback level passes through SYNC_STAGES flip-flops. A rising edge seen by the block raises `blank_o` SYNC_STAGES clock edges after the first clock edge that samples the pin high, provided horizontal blanking is enabled.
- R3: With `hblank_en_i` = 0 (standard 4:3), the horizontal window never drives `blank_o` high, whatever `wide_i` is.
- R4: With `hblank_en_i` = 1 and `wide_i` = 0 (14:9), and a stable line period, each line blanks for LEAD_N + TRAIL_N + 1 cycles. LEAD_N cycles come before the edge cycle, then the edge cycle, then TRAIL_N cycles after it. Lead and trail are the nanosecond parameters (1.7 µs and 13.7 µs) times the clock in MHz, rounded to the nearest cycle.
- R5: With `hblank_en_i` = 1 and `wide_i` = 1 (16:9), the same holds with a 3.2 µs lead and a 15.2 µs trail.
- R6: `blank_o` is high one cycle after any cycle in which `vblank_i` is high, independent of the horizontal state.
- R7: The lead part is suppressed until two rising edges have been seen since reset. Before that, the window starts at the edge.
- R8: The line period is the count of clock cycles from one recognised rising edge to the next. The lead part opens when the cycle count since the last edge reaches period − 1 − lead. An edge that arrives earlier than the lead window gives a window with no lead part.
- R9: If an expected edge does not arrive, the lead window closes once the count since the last edge reaches period + lead. A missing edge therefore blanks for 2·lead + 1 cycles around the predicted position.
- R10: If the count since the last edge saturates at 2^CNT_W − 1 before an edge arrives, the period is discarded. The next edge is treated like the first edge after reset, so R7 applies again.
- R11: The mode pins are read every cycle for enabling and for the lead length. The trail length is taken from `wide_i` in the cycle of the edge and holds for that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; the frequency in MHz is the CLK_MHZ parameter |
| rst_n | input | 1 | Asynchronous active-low reset |
| flyback_i | input | 1 | Sliced horizontal flyback level, high during flyback, asynchronous |
| hblank_en_i | input | 1 | 1 enables the horizontal window (14:9 or 16:9), 0 selects 4:3 |
| wide_i | input | 1 | With the window enabled: 0 selects 14:9 timing, 1 selects 16:9 timing |
| vblank_i | input | 1 | Vertical blanking request, OR-ed into the output |
| blank_o | output | 1 | Combined blanking level, 1 = blank |

## Verification
The bench builds the block with a 10 MHz clock, an 11-bit line counter and two synchronizer stages. The 10 MHz clock gives lead and trail counts of 17/137 and 32/152 cycles, so a 640-cycle line leaves clear gaps between windows. The 11-bit counter saturates after 2047 cycles, so a single missing-pulse gap of about 2200 cycles reaches the R10 discard path within a short run. A behavioural model tracks the edge history, period and trail with plain integers and is compared on every clock. It is backed by per-line window counts for early edges, missing edges, mode switches within a line and vertical blanking.

// File: rtl/hob_pkg.sv
package hob_pkg;

  typedef struct packed {
    logic h_on;   // horizontal window enabled
    logic wide;   // 1: 16:9 timing, 0: 14:9 timing
  } hob_mode_t;

  // nanoseconds to clock cycles, rounded to nearest
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    return (ns * mhz + 500) / 1000;
  endfunction

endpackage

// File: rtl/hob_edge_sync.sv
module hob_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fly_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= fly_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], fly_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise_o |=> !rise_o);  // R2

endmodule

// File: rtl/hob_line_meter.sv
module hob_line_meter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [1:0]       seen_q;   // edges since reset or since discard, saturating at 2
  logic             sat;

  assign sat = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      period_q <= '0;
      seen_q   <= 2'd0;
    end else if (rise_i) begin
      cnt_q <= '0;
      if (sat) begin
        seen_q <= 2'd1;
      end else begin
        period_q <= cnt_q + 1'b1;
        if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      end
    end else if (!sat) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign period_o = period_q;
  assign valid_o  = (seen_q == 2'd2);

  AST_CNT_RESTART:  assert property (@(posedge clk) disable iff (!rst_n) rise_i |=> (cnt_o == '0));  // R8
  AST_PERIOD_TAKE:  assert property (@(posedge clk) disable iff (!rst_n) (rise_i && !sat) |=> (period_o == $past(cnt_o) + 1'b1));  // R8
  AST_SAT_DISCARD:  assert property (@(posedge clk) disable iff (!rst_n) (rise_i && sat) |=> !valid_o);  // R10
  AST_VALID_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (!valid_o && !rise_i) |=> !valid_o);  // R7

endmodule

// File: rtl/hob_window.sv
module hob_window
  import hob_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned LEAD_N  = 46,
  parameter int unsigned TRAIL_N = 370,
  parameter int unsigned LEAD_W  = 86,
  parameter int unsigned TRAIL_W = 410
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hob_mode_t        mode_i,
  input  logic             vblank_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             pvalid_i,
  output logic             blank_o
);

  localparam int unsigned XW      = CNT_W + 2;
  localparam int unsigned TR_MAX  = (TRAIL_W > TRAIL_N) ? TRAIL_W : TRAIL_N;
  localparam int unsigned TRW     = $clog2(TR_MAX + 2);
  localparam logic [XW-1:0]  LN_X = XW'(LEAD_N);
  localparam logic [XW-1:0]  LW_X = XW'(LEAD_W);
  localparam logic [TRW-1:0] TN_T = TRW'(TRAIL_N);
  localparam logic [TRW-1:0] TW_T = TRW'(TRAIL_W);

  logic [TRW-1:0] trail_q;
  logic [XW-1:0]  lead_x, cnt_x, per_x;
  logic           lead_hit, h_win, blank_q;

  assign lead_x = mode_i.wide ? LW_X : LN_X;
  assign cnt_x  = {2'b00, cnt_i};
  assign per_x  = {2'b00, period_i};

  // predicted-edge window: [period-1-lead, period+lead-1]
  assign lead_hit = pvalid_i
                  && ((cnt_x + lead_x + XW'(1)) >= per_x)
                  && (cnt_x < (per_x + lead_x));

  assign h_win = mode_i.h_on && (rise_i || (trail_q != '0) || lead_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trail_q <= '0;
      blank_q <= 1'b0;
    end else begin
      if (rise_i)               trail_q <= mode_i.wide ? TW_T : TN_T;
      else if (trail_q != '0)   trail_q <= trail_q - 1'b1;
      blank_q <= vblank_i || h_win;
    end
  end

  assign blank_o = blank_q;

  AST_MODE_OFF:    assert property (@(posedge clk) disable iff (!rst_n) (!mode_i.h_on && !vblank_i) |=> !blank_o);  // R3
  AST_VBLANK_OR:   assert property (@(posedge clk) disable iff (!rst_n) vblank_i |=> blank_o);  // R6
  AST_EDGE_BLANK:  assert property (@(posedge clk) disable iff (!rst_n) (mode_i.h_on && rise_i) |=> blank_o);  // R2
  AST_TRAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (trail_q <= TRW'(TR_MAX)));  // R11
  AST_NO_EARLY_LEAD: assert property (@(posedge clk) disable iff (!rst_n) (!pvalid_i && !rise_i && trail_q == '0 && !vblank_i) |=> !blank_o);  // R7

endmodule

// File: rtl/hob_timer.sv
module hob_timer
  import hob_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 27,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD_N_NS   = 1700,
  parameter int unsigned TRAIL_N_NS  = 13700,
  parameter int unsigned LEAD_W_NS   = 3200,
  parameter int unsigned TRAIL_W_NS  = 15200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flyback_i,
  input  logic hblank_en_i,
  input  logic wide_i,
  input  logic vblank_i,
  output logic blank_o
);

  localparam int unsigned LEAD_N  = ns_to_cycles(LEAD_N_NS,  CLK_MHZ);
  localparam int unsigned TRAIL_N = ns_to_cycles(TRAIL_N_NS, CLK_MHZ);
  localparam int unsigned LEAD_W  = ns_to_cycles(LEAD_W_NS,  CLK_MHZ);
  localparam int unsigned TRAIL_W = ns_to_cycles(TRAIL_W_NS, CLK_MHZ);

  hob_mode_t        mode;
  logic             rise;
  logic [CNT_W-1:0] cnt, period;
  logic             pvalid;

  assign mode.h_on = hblank_en_i;
  assign mode.wide = wide_i;

  hob_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .fly_i(flyback_i), .rise_o(rise)
  );

  hob_line_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .cnt_o(cnt), .period_o(period), .valid_o(pvalid)
  );

  hob_window #(
    .CNT_W(CNT_W), .LEAD_N(LEAD_N), .TRAIL_N(TRAIL_N),
    .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .vblank_i(vblank_i),
    .rise_i(rise), .cnt_i(cnt), .period_i(period), .pvalid_i(pvalid),
    .blank_o(blank_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ($rose(rst_n) |-> !blank_o));  // R1

endmodule

// File: tb/hob_timer_tb.sv
module hob_timer_tb;

  localparam int CLK_PERIOD = 100;   // 10 MHz
  localparam int MHZ  = 10;
  localparam int CW   = 11;
  localparam int SYNC = 2;
  localparam int CMAX = (1 << CW) - 1;
  // 1.7/13.7 us and 3.2/15.2 us at 10 MHz
  localparam int LN = 17, TN = 137, LW = 32, TW = 152;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fly = 1'b0, hen = 1'b0, wide = 1'b0, vbl = 1'b0;
  logic blank;

  int checks = 0, errors = 0;
  int bcount = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hob_timer #(.CLK_MHZ(MHZ), .CNT_W(CW), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .flyback_i(fly), .hblank_en_i(hen),
    .wide_i(wide), .vblank_i(vbl), .blank_o(blank)
  );

  // behavioural reference model
  bit hist[$];
  int m_cnt, m_per, m_seen, m_trail;
  bit m_blank;

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
    m_cnt = 0; m_per = 0; m_seen = 0; m_trail = 0; m_blank = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit r, lead, nb;
      int L, T;
      r    = hist[SYNC-1] && !hist[SYNC];
      L    = wide ? LW : LN;
      T    = wide ? TW : TN;
      lead = (m_seen == 2) && (m_cnt + L + 1 >= m_per) && (m_cnt < m_per + L);
      nb   = vbl || (hen && (r || m_trail > 0 || lead));
      if (r) begin
        if (m_cnt == CMAX) m_seen = 1;
        else begin
          m_per = m_cnt + 1;
          if (m_seen < 2) m_seen++;
        end
        m_cnt = 0;
        m_trail = T;
      end else begin
        if (m_cnt < CMAX) m_cnt++;
        if (m_trail > 0) m_trail--;
      end
      hist.push_front(fly);
      void'(hist.pop_back());
      m_blank = nb;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done)
      check(blank == m_blank, cur_req, "blank_o vs model", int'(blank), int'(m_blank));
  end

  // one line: pulse for hi cycles; snapshot of blank count at index SYNC+1
  task automatic run_line(input int per, input int hi, input int vb_lo,
                          input int vb_hi, input int sw_idx, input bit sw_wide,
                          output int snap);
    snap = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      fly = (i < hi);
      vbl = (i >= vb_lo) && (i < vb_hi);
      if (i == sw_idx) wide = sw_wide;
      if (i == SYNC + 1) snap = bcount;
      if (blank) bcount++;
    end
  endtask

  task automatic line(input int per, input int hi, output int snap);
    run_line(per, hi, -1, -1, -1, 1'b0, snap);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fly = 1'b0; vbl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    int s[0:40];
    repeat (2) @(negedge clk);
    check(blank == 1'b0, "R1", "blank during reset", int'(blank), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(blank == 1'b0, "R1", "blank after reset", int'(blank), 0);

    // R3: 4:3 mode, wide ignored
    cur_req = "R3"; hen = 1'b0; wide = 1'b1;
    for (int k = 0; k < 3; k++) line(640, 100, s[k]);
    check(s[2] - s[1] == 0, "R3", "window count 4:3", s[2] - s[1], 0);

    // R7, R4, R2: fresh start in 14:9
    do_reset();
    cur_req = "R7"; hen = 1'b1; wide = 1'b0;
    line(640, 100, s[1]);
    check(s[1] == 0, "R2", "no blank before first edge", s[1], 0);
    line(640, 100, s[2]);
    check(s[2] - s[1] == TN + 1, "R7", "first window without lead", s[2] - s[1], TN + 1);
    cur_req = "R4";
    line(640, 100, s[3]);
    line(640, 100, s[4]);
    line(640, 100, s[5]);
    check(s[3] - s[2] == LN + TN + 1, "R4", "14:9 window", s[3] - s[2], LN + TN + 1);
    check(s[5] - s[4] == LN + TN + 1, "R4", "14:9 window steady", s[5] - s[4], LN + TN + 1);

    // R5: 16:9
    cur_req = "R5"; wide = 1'b1;
    line(640, 100, s[6]);
    line(640, 100, s[7]);
    line(640, 100, s[8]);
    check(s[8] - s[7] == LW + TW + 1, "R5", "16:9 window", s[8] - s[7], LW + TW + 1);

    // R11: switch to 14:9 after the edge; trail stays 16:9 length
    cur_req = "R11";
    run_line(640, 100, -1, -1, 10, 1'b0, s[9]);
    line(640, 100, s[10]);
    check(s[10] - s[9] == TW + 1 + LN, "R11", "trail latched at edge", s[10] - s[9], TW + 1 + LN);

    // R8: period change 640 -> 500
    cur_req = "R8"; wide = 1'b0;
    line(640, 100, s[11]);
    line(500, 100, s[12]);
    line(500, 100, s[13]);
    line(500, 100, s[14]);
    check(s[13] - s[12] == TN + 1, "R8", "early edge no lead", s[13] - s[12], TN + 1);
    check(s[14] - s[13] == LN + TN + 1, "R8", "new period learned", s[14] - s[13], LN + TN + 1);

    // R9: missing edge
    cur_req = "R9";
    line(640, 100, s[15]);
    line(640, 100, s[16]);
    line(1300, 0, s[17]);
    line(640, 100, s[18]);
    check(s[18] - s[16] == TN + 1 + 2 * LN + 1, "R9", "missing edge window", s[18] - s[16], TN + 2 + 2 * LN);
    line(640, 100, s[19]);

    // R10: saturating gap discards period
    cur_req = "R10";
    line(640, 100, s[20]);
    line(2200, 0, s[21]);
    line(640, 100, s[22]);
    line(640, 100, s[23]);
    line(640, 100, s[24]);
    check(s[23] - s[22] == TN + 1, "R10", "lead suppressed after saturation", s[23] - s[22], TN + 1);
    check(s[24] - s[23] == LN + TN + 1, "R10", "period relearned", s[24] - s[23], LN + TN + 1);

    // R6: vertical blank alone, then overlapping a window
    cur_req = "R6"; hen = 1'b0;
    line(640, 100, s[25]);
    run_line(640, 100, 100, 150, -1, 1'b0, s[26]);
    line(640, 100, s[27]);
    check(s[27] - s[26] == 50, "R6", "vertical blank count", s[27] - s[26], 50);
    hen = 1'b1;
    run_line(640, 100, 5, 400, -1, 1'b0, s[28]);
    line(640, 100, s[29]);
    line(640, 100, s[30]);

    repeat (5) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule